// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address through three programmable windows. Every window has a base register, which gives the local start address, size and enable, and a map register, which gives the bus start address, the cycle type and how the two lowest address bits are driven. Windows 0 and 1 carry PCI memory traffic. Window 2 is a fixed 16 MB region for PCI I/O.

Windows may overlap. The enabled windows are searched from index 0 upward, and the first one that contains the address supplies the translation. Software relies on this: it widens window 0 to 512 MB so that window 1 is hidden, points window 1 at configuration space, runs its configuration cycles, and then restores both windows. An access that no window claims raises a miss flag, and a read that misses returns all ones.

Writes to the base and map registers pass through a lock. The lock is a two-state machine. Its states are LOCKED, which is the reset state, and OPEN. The transition UNLOCK goes from LOCKED to OPEN when the key is written to the system register. The transition RELOCK goes from OPEN to LOCKED when the system register is written with the lock bit set. Results come out one clock after the access is presented.

Top module: `addr_window_xlat`

## Requirements
- R1: The windows are searched in ascending index, and the lowest-numbered enabled window that contains the address is reported on `res_win` and supplies the translation, even when a higher-numbered window also contains the address.
- R2: Base bits 5:4 select the size of window 0 or window 1: 00 is 16 MB, 01 is 256 MB, 10 is 512 MB, and 11 is 16 MB. A window contains an address when the address bits above the size equal the same bits of base bits 31:24. Window 2 is always 16 MB, whatever value its size field holds.
- R3: Base bit 0 enables the window. A window whose bit 0 is clear never matches.
- R4: The translated address is map bits 31:4 (with zeros below them) masked to the bits above the window size, ORed with the local address bits below the window size. When map bit 0 is clear, address bits 1:0 are forced to zero. When map bit 0 is set, they pass through from the local address.
- R5: `res_cycle` is map bits 3:1 of the selected window. Value 3'b101 is a configuration cycle and sets `res_is_cfg`. The other codes are 001 for I/O, 011 for memory and 110 for memory read multiple.
- R6: After reset the windows are set up as follows. Window 0 maps local 0x40000000, 256 MB, to bus 0x00000000 with memory cycles. Window 1 maps local 0x50000000, 256 MB, to bus 0x10000000 with memory-read-multiple cycles. Window 2 maps local 0x60000000, 16 MB, to I/O address 0, with the low bits passed through.
- R7: The lock is set after reset, and `cfg_locked` shows it. While the lock is set, writes to the base and map registers (select 2w for the base of window w, 2w+1 for its map) are ignored.
- R8: The system register is select 6. Writing 16'hA05F to its low half clears the lock. Any other write to it with bit 14 set sets the lock. Other writes to it leave the lock unchanged.
- R9: An access that matches no window sets `res_miss`. It returns a window index of 0, address 0 and cycle 0. `res_rdata` is all ones for a read that misses and zero for every other access.
- R10: A result appears on the outputs, with `res_valid` high, one clock after `acc_valid`. A register write in the same cycle as an access is not seen by that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select: 2w base, 2w+1 map, 6 system |
| cfg_wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Local-bus access presented |
| acc_read | input | 1 | Access is a read |
| acc_addr | input | 32 | Local-bus address |
| res_valid | output | 1 | Translation result valid |
| res_miss | output | 1 | No window matched |
| res_win | output | 2 | Index of the winning window |
| res_addr | output | 32 | Translated bus address |
| res_cycle | output | 3 | Cycle type code |
| res_is_cfg | output | 1 | Configuration cycle |
| res_rdata | output | 32 | Read data returned on a miss |
| cfg_locked | output | 1 | Register lock is set |

## Verification
The assertions check, on every cycle, the following properties:
- results arrive one clock after the access;
- the window registers do not move while the lock is set, or when nothing writes them;
- the UNLOCK and RELOCK transitions follow the system-register writes;
- a missed access drives zeros and returns all ones only for reads.

Only the bench's scenarios can show that overlapping windows resolve to the lowest index, that each size and the fixed I/O window decode the right range, and that map bit 0 controls the low address bits. The same holds for the configuration-window sequence: widen window 0, retarget window 1, then restore both.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W      = 32;
    localparam int NUM_WIN     = 3;
    localparam int NUM_MEM_WIN = 2;
    localparam int SEL_W       = 3;
    localparam int WIN_IDX_W   = 2;
    localparam int CYC_W       = 3;
    localparam int SH_W        = 6;

    // register selects: 2w = base of window w, 2w+1 = map of window w
    localparam logic [SEL_W-1:0] SEL_SYS = 3'd6;

    // window size shifts (log2 of bytes)
    localparam int SH_16M  = 24;
    localparam int SH_256M = 28;
    localparam int SH_512M = 29;

    // base register fields
    localparam int BASE_EN_BIT = 0;
    localparam int BASE_SZ_LSB = 4;
    localparam logic [1:0] SZ_256M = 2'b01;
    localparam logic [1:0] SZ_512M = 2'b10;

    // map register fields
    localparam int MAP_LOWEN_BIT = 0;
    localparam int MAP_CYC_LSB   = 1;
    localparam int MAP_BASE_LSB  = 4;

    // cycle codes
    localparam logic [CYC_W-1:0] CYC_NONE = 3'b000;
    localparam logic [CYC_W-1:0] CYC_IO   = 3'b001;
    localparam logic [CYC_W-1:0] CYC_MEM  = 3'b011;
    localparam logic [CYC_W-1:0] CYC_CFG  = 3'b101;
    localparam logic [CYC_W-1:0] CYC_MRM  = 3'b110;

    // system register lock control
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam int          LOCK_BIT   = 14;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_t;

    // reset layout, index 0 at the right
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] BASE_RST = {
        32'h6000_0001,   // window 2: 16 MB I/O, enabled
        32'h5000_0011,   // window 1: 256 MB, enabled
        32'h4000_0011    // window 0: 256 MB, enabled
    };
    localparam logic [NUM_WIN-1:0][ADDR_W-1:0] MAP_RST = {
        32'h0000_0003,   // I/O at 0, low bits passed
        32'h1000_000C,   // bus 0x10000000, read multiple
        32'h0000_0006    // bus 0x00000000, memory
    };
endpackage

// File: rtl/xlat_lock_fsm.sv
module xlat_lock_fsm
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_wr,
    input  logic [15:0] sys_data,
    output logic        locked
);
    lock_state_t state_q, state_d;
    logic        key_hit;
    logic        relock_req;

    assign key_hit    = sys_wr && (sys_data == UNLOCK_KEY);
    assign relock_req = sys_wr && !key_hit && sys_data[LOCK_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // transitions: UNLOCK and RELOCK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_hit)    state_d = LK_OPEN;
            LK_OPEN:   if (relock_req) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        locked = (state_q == LK_LOCKED);
    end
endmodule

// File: rtl/xlat_regfile.sv
module xlat_regfile
    import xlat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WIN
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [AW-1:0]         wr_data,
    input  logic                  locked,
    output logic [NW-1:0][AW-1:0] base_q,
    output logic [NW-1:0][AW-1:0] map_q
);
    logic wr_ok;
    assign wr_ok = wr_en && !locked;

    for (genvar w = 0; w < NW; w++) begin : g_win
        localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(2 * w);
        localparam logic [SEL_W-1:0] SEL_MAP  = SEL_W'(2 * w + 1);
        logic [AW-1:0] base_r;
        logic [AW-1:0] map_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= BASE_RST[w];
                map_r  <= MAP_RST[w];
            end else if (wr_ok) begin
                if (wr_sel == SEL_BASE) base_r <= wr_data;
                if (wr_sel == SEL_MAP)  map_r  <= wr_data;
            end
        end

        assign base_q[w] = base_r;
        assign map_q[w]  = map_r;
    end
endmodule

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter bit FIXED    = 1'b0,
    parameter int FIXED_SH = SH_16M
)(
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    map,
    output logic             hit,
    output logic [AW-1:0]    xaddr,
    output logic [CYC_W-1:0] cycle
);
    logic [SH_W-1:0] size_sh;
    logic [AW-1:0]   hi_mask;
    logic [AW-1:0]   map_base;
    logic [AW-1:0]   bus;

    always_comb begin
        unique case (base[BASE_SZ_LSB +: 2])
            SZ_256M: size_sh = SH_W'(SH_256M);
            SZ_512M: size_sh = SH_W'(SH_512M);
            default: size_sh = SH_W'(SH_16M);
        endcase
        if (FIXED) size_sh = SH_W'(FIXED_SH);
    end

    assign hi_mask  = {AW{1'b1}} << size_sh;
    assign map_base = {map[AW-1:MAP_BASE_LSB], {MAP_BASE_LSB{1'b0}}};
    assign hit      = base[BASE_EN_BIT] && (((addr ^ base) & hi_mask) == '0);

    always_comb begin
        bus = (map_base & hi_mask) | (addr & ~hi_mask);
        if (!map[MAP_LOWEN_BIT]) bus[1:0] = 2'b00;
        xaddr = bus;
    end

    assign cycle = map[MAP_CYC_LSB +: CYC_W];
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              acc_valid,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              res_valid,
    output logic              res_miss,
    output logic [WIN_IDX_W-1:0] res_win,
    output logic [ADDR_W-1:0] res_addr,
    output logic [CYC_W-1:0]  res_cycle,
    output logic              res_is_cfg,
    output logic [ADDR_W-1:0] res_rdata,
    output logic              cfg_locked
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_map;
    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_xaddr;
    logic [NUM_WIN-1:0][CYC_W-1:0]  win_cyc;
    logic                           locked;

    xlat_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_wr   (cfg_wr_en && (cfg_wr_sel == SEL_SYS)),
        .sys_data (cfg_wr_data[15:0]),
        .locked   (locked)
    );

    xlat_regfile #(.AW(ADDR_W), .NW(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .locked  (locked),
        .base_q  (win_base),
        .map_q   (win_map)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        xlat_window #(
            .AW       (ADDR_W),
            .FIXED    (w >= NUM_MEM_WIN),
            .FIXED_SH (SH_16M)
        ) u_win (
            .addr  (acc_addr),
            .base  (win_base[w]),
            .map   (win_map[w]),
            .hit   (win_hit[w]),
            .xaddr (win_xaddr[w]),
            .cycle (win_cyc[w])
        );
    end

    // first match in ascending order
    logic                 found;
    logic [WIN_IDX_W-1:0] pick_idx;
    logic [ADDR_W-1:0]    pick_addr;
    logic [CYC_W-1:0]     pick_cyc;

    always_comb begin
        found     = 1'b0;
        pick_idx  = '0;
        pick_addr = '0;
        pick_cyc  = CYC_NONE;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (!found && win_hit[w]) begin
                found     = 1'b1;
                pick_idx  = WIN_IDX_W'(w);
                pick_addr = win_xaddr[w];
                pick_cyc  = win_cyc[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_miss   <= 1'b0;
            res_win    <= '0;
            res_addr   <= '0;
            res_cycle  <= CYC_NONE;
            res_is_cfg <= 1'b0;
            res_rdata  <= '0;
        end else begin
            res_valid  <= acc_valid;
            res_miss   <= acc_valid && !found;
            res_win    <= acc_valid ? pick_idx : '0;
            res_addr   <= acc_valid ? pick_addr : '0;
            res_cycle  <= acc_valid ? pick_cyc : CYC_NONE;
            res_is_cfg <= acc_valid && found && (pick_cyc == CYC_CFG);
            res_rdata  <= (acc_valid && !found && acc_read) ? '1 : '0;
        end
    end

    assign cfg_locked = locked;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
    import xlat_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_wr_en,
    input logic [SEL_W-1:0]               cfg_wr_sel,
    input logic [ADDR_W-1:0]              cfg_wr_data,
    input logic                           acc_valid,
    input logic                           acc_read,
    input logic                           res_valid,
    input logic                           res_miss,
    input logic [ADDR_W-1:0]              res_addr,
    input logic [CYC_W-1:0]               res_cycle,
    input logic                           res_is_cfg,
    input logic [ADDR_W-1:0]              res_rdata,
    input logic                           cfg_locked,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_base,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_map
);
    // R10
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    // R10
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R7
    locked_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locked && cfg_wr_en && cfg_wr_sel != SEL_SYS)
        |=> ($stable(win_base) && $stable(win_map)));

    // R7
    idle_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(win_base) && $stable(win_map)));

    // R8
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_sel == SEL_SYS && cfg_wr_data[15:0] == UNLOCK_KEY)
        |=> !cfg_locked);

    // R8
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_sel == SEL_SYS && cfg_wr_data[LOCK_BIT]
         && cfg_wr_data[15:0] != UNLOCK_KEY)
        |=> cfg_locked);

    // R9
    miss_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss)
        |-> (res_addr == '0 && res_cycle == CYC_NONE && !res_is_cfg));

    // R9
    miss_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_read) |=> (res_miss == (res_rdata == '1)));

    // R9
    hit_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_miss) |-> (res_rdata == '0));
endmodule

bind addr_window_xlat xlat_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .acc_valid   (acc_valid),
    .acc_read    (acc_read),
    .res_valid   (res_valid),
    .res_miss    (res_miss),
    .res_addr    (res_addr),
    .res_cycle   (res_cycle),
    .res_is_cfg  (res_is_cfg),
    .res_rdata   (res_rdata),
    .cfg_locked  (cfg_locked),
    .win_base    (win_base),
    .win_map     (win_map)
);

// File: tb/addr_window_xlat_bench.sv
`timescale 1ns/1ps
module addr_window_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [2:0]  cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic        acc_valid;
    logic        acc_read;
    logic [31:0] acc_addr;
    logic        res_valid;
    logic        res_miss;
    logic [1:0]  res_win;
    logic [31:0] res_addr;
    logic [2:0]  res_cycle;
    logic        res_is_cfg;
    logic [31:0] res_rdata;
    logic        cfg_locked;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    addr_window_xlat u_addr_window_xlat (.*);

    typedef struct packed {
        logic        miss;
        logic [1:0]  win;
        logic [31:0] addr;
        logic [2:0]  cyc;
        logic        cfg;
        logic [31:0] rdata;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic exp_t mk(input logic rd, input logic m, input logic [1:0] w,
                                input logic [31:0] xa, input logic [2:0] c);
        exp_t e;
        e.miss  = m;
        e.win   = m ? 2'd0 : w;
        e.addr  = m ? 32'h0 : xa;
        e.cyc   = m ? 3'b000 : c;
        e.cfg   = !m && (c == 3'b101);
        e.rdata = (m && rd) ? 32'hFFFF_FFFF : 32'h0;
        return e;
    endfunction

    // driver: pushes the expected item, then drives one access
    task automatic access(input logic [31:0] a, input logic rd, input logic m,
                          input logic [1:0] w, input logic [31:0] xa,
                          input logic [2:0] c, input string tag);
        exp_q.push_back(mk(rd, m, w, xa, c));
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_read = rd;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr_and_access(input logic [2:0] sel, input logic [31:0] d,
                                 input logic [31:0] a, input logic m,
                                 input logic [1:0] w, input logic [31:0] xa,
                                 input logic [2:0] c, input string tag);
        exp_q.push_back(mk(1'b1, m, w, xa, c));
        tag_q.push_back(tag);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        acc_valid = 1'b1; acc_addr = a; acc_read = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; acc_valid = 1'b0;
    endtask

    // monitor: pops and compares each result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10: unexpected result addr=%h expected none", res_addr);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_miss, res_win, res_addr, res_cycle, res_is_cfg, res_rdata} !== e) begin
                    failures++;
                    $display("FAIL %s: actual miss=%0b win=%0d addr=%h cyc=%b cfg=%0b rdata=%h expected miss=%0b win=%0d addr=%h cyc=%b cfg=%0b rdata=%h",
                             t, res_miss, res_win, res_addr, res_cycle, res_is_cfg, res_rdata,
                             e.miss, e.win, e.addr, e.cyc, e.cfg, e.rdata);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0;
        acc_valid = 1'b0; acc_read = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R10 reset valid", 32'(res_valid), 32'd0);
        chk(cfg_locked == 1'b1, "R7 reset lock", 32'(cfg_locked), 32'd1);

        // R6 reset layout, R4 low bits, R5 cycle codes
        access(32'h4000_1237, 1, 0, 2'd0, 32'h0000_1234, 3'b011, "R6 win0");
        access(32'h5ABC_DEF3, 0, 0, 2'd1, 32'h1ABC_DEF0, 3'b110, "R6 win1");
        access(32'h6000_0103, 1, 0, 2'd2, 32'h0000_0103, 3'b001, "R6 win2");
        // R9 misses
        access(32'h6100_0000, 1, 1, 2'd0, 32'h0, 3'b000, "R9 read miss");
        access(32'h7000_0000, 0, 1, 2'd0, 32'h0, 3'b000, "R9 write miss");

        // R7 locked writes ignored
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0000);
        access(32'h5000_0000, 1, 0, 2'd1, 32'h1000_0000, 3'b110, "R7 locked write");
        // R8 non-key writes keep lock
        wr(3'd6, 32'h0000_1234);
        chk(cfg_locked == 1'b1, "R8 bogus write", 32'(cfg_locked), 32'd1);
        wr(3'd6, 32'h0000_A05F);
        chk(cfg_locked == 1'b0, "R8 unlock", 32'(cfg_locked), 32'd0);
        wr(3'd6, 32'h0000_0123);
        chk(cfg_locked == 1'b0, "R8 plain write", 32'(cfg_locked), 32'd0);

        // R1 widen window 0 to hide window 1
        wr(3'd0, 32'h4000_0021);
        access(32'h5000_0010, 1, 0, 2'd0, 32'h1000_0010, 3'b011, "R1 overlap");
        // R5 configuration window in window 1
        wr(3'd2, 32'h6100_0001);
        wr(3'd3, 32'h0000_000A);
        access(32'h6100_0802, 1, 0, 2'd1, 32'h0000_0800, 3'b101, "R5 cfg low forced R4");
        wr(3'd3, 32'h0000_000B);
        access(32'h6100_0802, 1, 0, 2'd1, 32'h0000_0802, 3'b101, "R4 low passed");

        // R2 size code 11 is 16 MB
        wr(3'd0, 32'h4000_0031);
        access(32'h40FF_FFFC, 1, 0, 2'd0, 32'h00FF_FFFC, 3'b011, "R2 size11 in");
        access(32'h4100_0000, 1, 1, 2'd0, 32'h0, 3'b000, "R2 size11 out");
        // R2 window 2 fixed 16 MB
        wr(3'd4, 32'h6000_0021);
        access(32'h7F00_0000, 1, 1, 2'd0, 32'h0, 3'b000, "R2 fixed out");
        access(32'h60FF_FFFF, 1, 0, 2'd2, 32'h00FF_FFFF, 3'b001, "R2 fixed in");
        // R3 disabled windows never match
        wr(3'd4, 32'h6000_0020);
        access(32'h6000_0010, 1, 1, 2'd0, 32'h0, 3'b000, "R3 win2 off");
        wr(3'd0, 32'h4000_0020);
        access(32'h4000_0004, 0, 1, 2'd0, 32'h0, 3'b000, "R3 win0 off");

        // restore layout
        wr(3'd0, 32'h4000_0011);
        wr(3'd2, 32'h5000_0011);
        wr(3'd3, 32'h1000_000C);
        wr(3'd4, 32'h6000_0001);
        access(32'h5FFF_FFFF, 1, 0, 2'd1, 32'h1FFF_FFFC, 3'b110, "R1 restored win1");

        // R10 same-cycle write is not seen
        wr_and_access(3'd0, 32'h4000_0010, 32'h4000_0008, 0, 2'd0, 32'h0000_0008,
                      3'b011, "R10 same cycle");
        access(32'h4000_0008, 1, 1, 2'd0, 32'h0, 3'b000, "R10 after write R3");
        wr(3'd0, 32'h4000_0011);

        // R8 relock, then R7 ignored write
        wr(3'd6, 32'h0000_4000);
        chk(cfg_locked == 1'b1, "R8 relock", 32'(cfg_locked), 32'd1);
        wr(3'd0, 32'h0000_0000);
        access(32'h4000_000C, 1, 0, 2'd0, 32'h0000_000C, 3'b011, "R7 relocked");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 drained", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule